// File: doc/BRIEF.md
# Direction-Controlled Odometer Pulse Counter

This block counts pulses arriving on a set of asynchronous odometer lines, by default two, each with its own 16-bit up/down counter. A separate drive-state line can set the count direction. It does so only while the host has switched direction control on through a command register. While that control is off, every pulse counts upward whatever the drive state is. Each input is brought into the clock domain through a synchroniser before it is used. A count happens on the rising edge of a pulse line. The drive state that decides the direction is taken in the same cycle as the detected edge.

A periodic, single-cycle strobe copies every live counter into a readable latch, and copies the synchronised drive state into a status latch. The live counters keep running and are not cleared. The host reads the latched values and the control bit over a simple register bus, which has a combinational read port and a single-cycle write port.

Top module: `odo_pulse_counter`

## Requirements
- R1: After reset every counter, every latch and the direction-enable bit are zero, so every readable address returns 0.
- R2: While direction control is off (control bit 0 = 0), each rising edge on a pulse line adds 1 to that line's counter, whether the drive state is 0 or 1.
- R3: While direction control is on (control bit 0 = 1), a rising edge adds 1 when the synchronised drive state is 1 and subtracts 1 when it is 0.
- R4: Only a low-to-high transition counts: a line held high for many cycles gives exactly one count, and a falling edge gives none.
- R5: Each pulse line drives only its own counter. Line k is read at address k (address 0 for line 0, address 1 for line 1).
- R6: Counters wrap modulo 2^16: a decrement from 0x0000 gives 0xFFFF, and an increment from 0xFFFF gives 0x0000.
- R7: On a cycle with the strobe high, each latch takes the value of its counter. Between strobes a latch holds its value while the counter changes.
- R8: Address 2 bit 0 returns the drive state captured at the last strobe. The upper bits read 0, and a later drive change is not visible until the next strobe.
- R9: Address 3 bit 0 is the direction-enable bit. A write there sets it and a read returns it. A write to any other address changes neither it nor any latch.
- R10: Addresses 4 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_i | input | 2 | Asynchronous odometer pulse lines, one per counter |
| drive_i | input | 1 | Asynchronous drive-state line (1 = forward) |
| strobe_i | input | 1 | Single-cycle periodic capture strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Read data for rd_addr_i (combinational) |

## Verification
The hardest case to reach from the ports is the wrap of a counter in either direction. Without a load path, reaching 0xFFFF by counting up would take 65535 pulses. The stimulus instead switches direction control on with the drive state low, steps a fresh counter down from zero, and then steps it back up across the boundary. It also holds a pulse line high for many cycles to show that a level gives only one count. Between strobes it moves both the counters and the drive state, to show that the latches stay frozen.

// File: rtl/odo_pkg.sv
package odo_pkg;

    localparam int ODO_N_CH        = 2;
    localparam int ODO_CNT_W       = 16;
    localparam int ODO_ADDR_W      = 3;
    localparam int ODO_DATA_W      = 16;
    localparam int ODO_SYNC_STAGES = 2;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } odo_dir_e;

    typedef struct packed {
        logic     rise;
        odo_dir_e dir;
    } odo_event_t;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } odo_sel_e;

    function automatic odo_dir_e pick_dir(input logic dir_en, input logic drive);
        if (!dir_en) return DIR_UP;
        return drive ? DIR_UP : DIR_DOWN;
    endfunction

endpackage

// File: rtl/odo_sync.sv
module odo_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg_q[0] <= '0;
        else     stg_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg_q[s] <= '0;
            else     stg_q[s] <= stg_q[s-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/odo_rise.sv
module odo_rise #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/odo_chan.sv
module odo_chan
    import odo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  odo_event_t       ev,
    input  logic             strobe,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] lat
);
    logic [CNT_W-1:0] cnt_q, cnt_d, lat_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ev.rise) begin
            if (ev.dir == DIR_UP) cnt_d = cnt_q + CNT_W'(1);
            else                  cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lat_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (strobe) lat_q <= cnt_q;
        end
    end

    assign cnt = cnt_q;
    assign lat = lat_q;
endmodule

// File: rtl/odo_regs.sv
module odo_regs
    import odo_pkg::*;
#(
    parameter int N_CH   = 2,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [N_CH-1:0][CNT_W-1:0] lat,
    input  logic                       stat_lat,
    output logic                       dir_en,
    output logic [DATA_W-1:0]          rd_data
);
    localparam int ADDR_STAT = N_CH;
    localparam int ADDR_CTRL = N_CH + 1;

    logic     dir_en_q;
    odo_sel_e sel;
    logic     unused_wr;

    assign unused_wr = ^wr_data[DATA_W-1:1];

    always_ff @(posedge clk) begin
        if (rst)
            dir_en_q <= 1'b0;
        else if (wr_en && (wr_addr == ADDR_W'(ADDR_CTRL)))
            dir_en_q <= wr_data[0];
    end

    always_comb begin
        if (int'(rd_addr) < N_CH)               sel = SEL_COUNT;
        else if (rd_addr == ADDR_W'(ADDR_STAT)) sel = SEL_STAT;
        else if (rd_addr == ADDR_W'(ADDR_CTRL)) sel = SEL_CTRL;
        else                                    sel = SEL_NONE;
    end

    always_comb begin
        rd_data = '0;
        unique case (sel)
            SEL_COUNT: begin
                for (int k = 0; k < N_CH; k++)
                    if (rd_addr == ADDR_W'(k)) rd_data = DATA_W'(lat[k]);
            end
            SEL_STAT: rd_data = DATA_W'(stat_lat);
            SEL_CTRL: rd_data = DATA_W'(dir_en_q);
            SEL_NONE: rd_data = '0;
        endcase
    end

    assign dir_en = dir_en_q;
endmodule

// File: rtl/odo_pulse_counter.sv
module odo_pulse_counter
    import odo_pkg::*;
#(
    parameter int N_CH        = ODO_N_CH,
    parameter int CNT_W       = ODO_CNT_W,
    parameter int ADDR_W      = ODO_ADDR_W,
    parameter int DATA_W      = ODO_DATA_W,
    parameter int SYNC_STAGES = ODO_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CH-1:0]   pulse_i,
    input  logic              drive_i,
    input  logic              strobe_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [N_CH-1:0]            pulse_s;
    logic [N_CH-1:0]            rise;
    logic                       drive_s;
    logic                       dir_en;
    logic                       stat_q;
    logic [N_CH-1:0][CNT_W-1:0] cnt;
    logic [N_CH-1:0][CNT_W-1:0] lat;

    odo_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_sync_pulse (
        .clk(clk), .rst(rst), .d(pulse_i), .q(pulse_s)
    );

    odo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_drive (
        .clk(clk), .rst(rst), .d(drive_i), .q(drive_s)
    );

    odo_rise #(.W(N_CH)) u_rise (
        .clk(clk), .rst(rst), .lvl(pulse_s), .rise(rise)
    );

    for (genvar k = 0; k < N_CH; k++) begin : g_chan
        odo_event_t ev;
        always_comb begin
            ev.rise = rise[k];
            ev.dir  = pick_dir(dir_en, drive_s);
        end
        odo_chan #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst(rst), .ev(ev), .strobe(strobe_i),
            .cnt(cnt[k]), .lat(lat[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)           stat_q <= 1'b0;
        else if (strobe_i) stat_q <= drive_s;
    end

    odo_regs #(.N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
        .rd_addr(rd_addr_i), .lat(lat), .stat_lat(stat_q),
        .dir_en(dir_en), .rd_data(rd_data_o)
    );
endmodule

// File: rtl/odo_pulse_counter_chk.sv
module odo_pulse_counter_chk #(
    parameter int N_CH   = 2,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic [N_CH-1:0]            rise,
    input logic                       drive_s,
    input logic                       dir_en,
    input logic                       strobe_i,
    input logic                       stat_q,
    input logic                       wr_en_i,
    input logic [ADDR_W-1:0]          wr_addr_i,
    input logic [N_CH-1:0][CNT_W-1:0] cnt,
    input logic [N_CH-1:0][CNT_W-1:0] lat
);
    localparam int ADDR_CTRL = N_CH + 1;

    AST_RESET_DIR_OFF: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dir_en == 1'b0)); // R1

    AST_CTRL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL))) |=> $stable(dir_en)); // R9

    AST_STAT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        strobe_i |=> (stat_q == $past(drive_s))); // R8

    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> $stable(stat_q)); // R8

    for (genvar k = 0; k < N_CH; k++) begin : g_chk
        AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (cnt[k] == '0 && lat[k] == '0)); // R1

        AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
            (rise[k] && (!dir_en || drive_s)) |=> (cnt[k] == CNT_W'($past(cnt[k]) + 1'b1))); // R2

        AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
            (rise[k] && dir_en && !drive_s) |=> (cnt[k] == CNT_W'($past(cnt[k]) - 1'b1))); // R3

        AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
            !rise[k] |=> $stable(cnt[k])); // R4

        AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (rst)
            strobe_i |=> (lat[k] == $past(cnt[k]))); // R7

        AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
            !strobe_i |=> $stable(lat[k])); // R7
    end
endmodule

bind odo_pulse_counter odo_pulse_counter_chk #(
    .N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst(rst), .rise(rise), .drive_s(drive_s), .dir_en(dir_en),
    .strobe_i(strobe_i), .stat_q(stat_q), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .cnt(cnt), .lat(lat)
);

// File: tb/odo_pulse_counter_tb_top.sv
module odo_pulse_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    // {dir_en, drive, pulses on line 0, pulses on line 1}
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'd5,  8'd3},
        {1'b1, 1'b0, 8'd2,  8'd4},
        {1'b1, 1'b1, 8'd7,  8'd1},
        {1'b0, 1'b1, 8'd1,  8'd2},
        {1'b1, 1'b0, 8'd10, 8'd0},
        {1'b0, 1'b0, 8'd0,  8'd6}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  pulse_i = '0;
    logic        drive_i = 1'b0;
    logic        strobe_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [2:0]  rd_addr_i = '0;
    logic [15:0] rd_data_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] exp0, exp1;

    always #(CLK_PERIOD/2) clk = ~clk;

    odo_pulse_counter dut_i (
        .clk(clk), .rst(rst), .pulse_i(pulse_i), .drive_i(drive_i),
        .strobe_i(strobe_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
    );

    task automatic check_rd(input logic [2:0] a, input logic [15:0] exp, input string req);
        rd_addr_i = a;
        #1;
        checks++;
        if (rd_data_o !== exp) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rd_data_o, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic set_drive(input logic v);
        @(negedge clk);
        drive_i = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulses(input int n0, input int n1);
        int n;
        n = (n0 > n1) ? n0 : n1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            pulse_i = {k < n1, k < n0};
            repeat (2) @(negedge clk);
            pulse_i = '0;
            repeat (2) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk);
        strobe_i = 1'b1;
        @(negedge clk);
        strobe_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: every address reads zero after reset
        for (int a = 0; a < 8; a++) check_rd(3'(a), 16'h0000, "R1");

        // Vector walk: R2, R3, R5, R6
        exp0 = '0; exp1 = '0;
        for (int v = 0; v < NV; v++) begin
            logic en, dv;
            int n0, n1;
            en = VEC[v][17]; dv = VEC[v][16];
            n0 = int'(VEC[v][15:8]); n1 = int'(VEC[v][7:0]);
            wr(3'd3, {15'd0, en});
            set_drive(dv);
            pulses(n0, n1);
            if (!en || dv) begin
                exp0 = exp0 + 16'(n0); exp1 = exp1 + 16'(n1);
            end else begin
                exp0 = exp0 - 16'(n0); exp1 = exp1 - 16'(n1);
            end
            strobe();
            check_rd(3'd0, exp0, (en && !dv) ? "R3 down line0" : "R2 up line0");
            check_rd(3'd1, exp1, (en && !dv) ? "R3 down line1 R6" : "R2 up line1 R5");
            check_rd(3'd2, {15'd0, dv}, "R8");
            check_rd(3'd3, {15'd0, en}, "R9");
        end

        // R6: wrap from 0 down and back up on a fresh counter
        rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
        wr(3'd3, 16'h0001);
        set_drive(1'b0);
        pulses(1, 0);
        strobe();
        check_rd(3'd0, 16'hFFFF, "R6 down wrap");
        set_drive(1'b1);
        pulses(1, 0);
        strobe();
        check_rd(3'd0, 16'h0000, "R6 up wrap");
        check_rd(3'd1, 16'h0000, "R5 line1 untouched");

        // R4: long high level counts once, falling edge counts none
        @(negedge clk); pulse_i = 2'b10;
        repeat (20) @(negedge clk);
        strobe();
        check_rd(3'd1, 16'h0001, "R4 held level");
        pulse_i = 2'b00;
        repeat (6) @(negedge clk);
        strobe();
        check_rd(3'd1, 16'h0001, "R4 falling edge");

        // R7 and R8: latches hold between strobes
        pulses(3, 0);
        set_drive(1'b0);
        check_rd(3'd0, 16'h0000, "R7 latch holds");
        check_rd(3'd2, 16'h0001, "R8 status holds");
        strobe();
        check_rd(3'd0, 16'h0003, "R7 latch capture");
        check_rd(3'd2, 16'h0000, "R8 status capture");

        // R9: writes elsewhere do not touch control or latches
        wr(3'd0, 16'h0000);
        wr(3'd2, 16'hFFFF);
        wr(3'd5, 16'h0000);
        check_rd(3'd3, 16'h0001, "R9 ctrl kept");
        check_rd(3'd0, 16'h0003, "R9 latch kept");
        wr(3'd3, 16'h0000);
        check_rd(3'd3, 16'h0000, "R9 ctrl cleared");

        // R10: unmapped addresses read zero with nonzero state
        for (int a = 4; a < 8; a++) check_rd(3'(a), 16'h0000, "R10");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule